// File: doc/BRIEF.md
# Alert Guard-Time Qualifier

This block turns a raw "both alert tones present" flag from a dual-tone detector into a clean, time-qualified, active-low steering output. Counters driven by a prescaled 100 µs tick stand in for the usual resistor-capacitor guard network. The time the raw flag must stay high before the output asserts and the time it must stay low before the output releases are two separate 16-bit tick counts. Either one may be the larger.

Next to the guard path, a pulse evaluator times each burst of the raw flag. Short dropouts inside a burst are tolerated. A dropout longer than the allowed span closes the burst. When a burst closes, the validity flag goes high only if the burst's tone-on length lies between a programmable minimum and maximum. The status output mirrors the internal guarded state. The tone filters that produce the raw flag sit outside this block.

Top module: `alert_guard_qual`

## Requirements
- R1: While rst_ni is low, std_no is 1, gt_o is 0 and valid_o is 0.
- R2: All durations are counted in ticks. One tick occurs every TICK_DIV clock cycles while the block is enabled. The prescaler restarts from zero when the block is enabled.
- R3: std_no goes low, and stays low, only once est_i has been high for present_ticks_i ticks in a row. Before that, std_no stays high.
- R4: If est_i drops while the present guard is still counting, the count restarts from zero.
- R5: Once std_no is low, it returns high only after est_i has been low for absent_ticks_i ticks in a row. A return of est_i to high before then restarts the absent count.
- R6: The present and absent guard times act independently, so either one may exceed the other.
- R7: gt_o is 1 exactly while std_no is 0. It rises when the present guard expires and falls when the absent guard expires.
- R8: A pulse opens when est_i is high while no pulse is open, and valid_o clears at that point. A run of low ticks closes the pulse only once it exceeds max_gap_i ticks. A shorter dropout leaves the pulse open.
- R9: When a pulse closes, valid_o goes to 1 if and only if min_dur_i <= L <= max_dur_i, where L is the tick count from the pulse start up to its last high tick. valid_o then holds its value until the next pulse opens.
- R10: When en_i is low, all counters clear, std_no is 1, gt_o is 0 and valid_o is 0 from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low clears all state |
| est_i | input | 1 | Raw dual-tone present flag |
| present_ticks_i | input | CNT_W | Present guard time in ticks |
| absent_ticks_i | input | CNT_W | Absent guard time in ticks |
| min_dur_i | input | CNT_W | Shortest accepted pulse, ticks |
| max_dur_i | input | CNT_W | Longest accepted pulse, ticks |
| max_gap_i | input | CNT_W | Longest dropout tolerated inside a pulse, ticks |
| std_no | output | 1 | Qualified steering output, active low |
| gt_o | output | 1 | Guarded-state status |
| valid_o | output | 1 | Last closed pulse met the duration window |

## Verification
The release of the steering output by the absent guard and the closing of a pulse by the evaluator can fall on the same tick. This happens when the absent guard equals one more than the allowed dropout span. One table row sets the absent guard to 4 ticks against a dropout limit of 3. After that low window, the bench requires both outcomes: std_no must have returned high, and valid_o must reflect the pulse's judged length. A property in the checker also requires that valid_o rises only on a tick that follows a low raw flag.

// File: rtl/agq_pkg.sv
package agq_pkg;
  typedef enum logic {
    EV_IDLE = 1'b0,
    EV_RUN  = 1'b1
  } ev_state_e;
endpackage

// File: rtl/agq_tick_gen.sv
module agq_tick_gen #(
  parameter int unsigned DIV = 358
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/agq_guard_timer.sv
module agq_guard_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         est_i,
  input  logic [W-1:0] on_ticks_i,
  input  logic [W-1:0] off_ticks_i,
  output logic         gt_o
);
  logic         gt_q;
  logic [W-1:0] cnt_q;
  logic [W:0]   cnt_inc;
  logic [W-1:0] thr;
  logic         differ;

  always_comb begin
    differ  = est_i != gt_q;
    thr     = gt_q ? off_ticks_i : on_ticks_i;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
  end

  // count consecutive ticks on which the raw flag disagrees with the guarded state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gt_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i || !differ) begin
      gt_q  <= en_i ? gt_q : 1'b0;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_inc >= {1'b0, thr}) begin
        gt_q  <= ~gt_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_inc[W-1:0];
      end
    end
  end

  assign gt_o = gt_q;
endmodule

// File: rtl/agq_pulse_eval.sv
module agq_pulse_eval
  import agq_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         est_i,
  input  logic [W-1:0] min_dur_i,
  input  logic [W-1:0] max_dur_i,
  input  logic [W-1:0] max_gap_i,
  output logic         valid_o
);
  ev_state_e    st_q;
  logic [W-1:0] len_q, gap_q, hi_q;
  logic [W-1:0] len_n, gap_n;
  logic         valid_q;
  logic         close_c, in_range;

  always_comb begin
    len_n    = (len_q == '1) ? len_q : len_q + 1'b1;
    gap_n    = (gap_q == '1) ? gap_q : gap_q + 1'b1;
    close_c  = tick_i && !est_i && (gap_n > max_gap_i);
    in_range = (hi_q >= min_dur_i) && (hi_q <= max_dur_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= EV_IDLE;
      len_q   <= '0;
      gap_q   <= '0;
      hi_q    <= '0;
      valid_q <= 1'b0;
    end else if (!en_i) begin
      st_q    <= EV_IDLE;
      len_q   <= '0;
      gap_q   <= '0;
      hi_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      case (st_q)
        EV_IDLE: if (est_i) begin
          st_q    <= EV_RUN;
          len_q   <= '0;
          gap_q   <= '0;
          hi_q    <= '0;
          valid_q <= 1'b0;
        end
        default: if (tick_i) begin
          len_q <= len_n;
          if (est_i) begin
            gap_q <= '0;
            hi_q  <= len_n;
          end else if (close_c) begin
            st_q    <= EV_IDLE;
            valid_q <= in_range;
          end else begin
            gap_q <= gap_n;
          end
        end
      endcase
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/alert_guard_qual.sv
module alert_guard_qual #(
  parameter int unsigned TICK_DIV = 358,
  parameter int unsigned CNT_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             est_i,
  input  logic [CNT_W-1:0] present_ticks_i,
  input  logic [CNT_W-1:0] absent_ticks_i,
  input  logic [CNT_W-1:0] min_dur_i,
  input  logic [CNT_W-1:0] max_dur_i,
  input  logic [CNT_W-1:0] max_gap_i,
  output logic             std_no,
  output logic             gt_o,
  output logic             valid_o
);
  logic tick;
  logic gt;

  agq_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_o (tick)
  );

  agq_guard_timer #(.W(CNT_W)) u_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .tick_i      (tick),
    .est_i       (est_i),
    .on_ticks_i  (present_ticks_i),
    .off_ticks_i (absent_ticks_i),
    .gt_o        (gt)
  );

  agq_pulse_eval #(.W(CNT_W)) u_eval (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tick_i    (tick),
    .est_i     (est_i),
    .min_dur_i (min_dur_i),
    .max_dur_i (max_dur_i),
    .max_gap_i (max_gap_i),
    .valid_o   (valid_o)
  );

  assign gt_o   = gt;
  assign std_no = ~gt;
endmodule

// File: rtl/alert_guard_qual_chk.sv
module alert_guard_qual_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic est_i,
  input logic tick,
  input logic std_no,
  input logic gt_o,
  input logic valid_o
);
  AST_DISABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (std_no && !gt_o && !valid_o)); // R10

  AST_ASSERT_NEEDS_TONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gt_o) |-> $past(est_i)); // R3

  AST_RELEASE_NEEDS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gt_o) && $past(en_i)) |-> !$past(est_i)); // R5

  AST_GUARD_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(gt_o) && $past(en_i)) |-> $past(tick)); // R2

  AST_VALID_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> ($past(tick) && !$past(est_i))); // R9

  AST_VALID_CLEAR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> ($past(est_i) || !$past(en_i))); // R8
endmodule

bind alert_guard_qual alert_guard_qual_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .est_i   (est_i),
  .tick    (tick),
  .std_no  (std_no),
  .gt_o    (gt_o),
  .valid_o (valid_o)
);

// File: tb/alert_guard_qual_tb.sv
module alert_guard_qual_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 4;
  localparam int W  = 16;

  typedef struct packed {
    logic [15:0] p;
    logic [15:0] a;
    logic [7:0]  len;
    logic        exp_std_n;
    logic        exp_valid;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd5,  16'd8,  8'd20, 1'b0, 1'b1},
    '{16'd25, 16'd4,  8'd20, 1'b1, 1'b1},
    '{16'd5,  16'd4,  8'd6,  1'b0, 1'b0},
    '{16'd3,  16'd10, 8'd35, 1'b0, 1'b0},
    '{16'd16, 16'd2,  8'd15, 1'b1, 1'b1},
    '{16'd40, 16'd3,  8'd8,  1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic est_i = 1'b0;
  logic [W-1:0] p_thr = 16'd5, a_thr = 16'd3;
  logic [W-1:0] min_d = 16'd10, max_d = 16'd30, max_g = 16'd3;
  logic std_no, gt_o, valid_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alert_guard_qual #(.TICK_DIV(TD), .CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .est_i(est_i),
    .present_ticks_i(p_thr), .absent_ticks_i(a_thr),
    .min_dur_i(min_d), .max_dur_i(max_d), .max_gap_i(max_g),
    .std_no(std_no), .gt_o(gt_o), .valid_o(valid_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; n rising edges see est_i = v, returns at a negedge
  task automatic drive(input logic v, input int n);
    est_i = v;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 std_no in reset", std_no, 1);
    chk("R1 gt_o in reset", gt_o, 0);
    chk("R1 valid_o in reset", valid_o, 0);
    rst_ni = 1'b1;
    en_i   = 1'b1;
    drive(1'b0, 3);

    foreach (VECS[i]) begin
      int lo;
      p_thr = VECS[i].p;
      a_thr = VECS[i].a;
      drive(1'b1, int'(VECS[i].len) * TD);
      chk($sformatf("R3/R6 vec%0d std_no", i), std_no, VECS[i].exp_std_n);
      chk($sformatf("R7 vec%0d gt_o", i), gt_o, !VECS[i].exp_std_n);
      lo = (int'(VECS[i].a) > 5) ? int'(VECS[i].a) + 2 : 7;
      drive(1'b0, lo * TD);
      chk($sformatf("R5 vec%0d release", i), std_no, 1);
      chk($sformatf("R9 vec%0d valid", i), valid_o, VECS[i].exp_valid);
    end

    // R3 present boundary, R4 restart on dropout
    p_thr = 16'd10;
    a_thr = 16'd20;
    drive(1'b1, 9 * TD);
    chk("R3 before present guard", std_no, 1);
    drive(1'b1, 2 * TD);
    chk("R3 after present guard", std_no, 0);
    // R5 absent boundary and restart
    drive(1'b0, 10 * TD);
    drive(1'b1, TD);
    drive(1'b0, 19 * TD);
    chk("R5 absent count restarted", std_no, 0);
    drive(1'b0, 2 * TD);
    chk("R5 after absent guard", std_no, 1);
    chk("R7 status low after release", gt_o, 0);
    drive(1'b0, 4 * TD);
    drive(1'b1, 8 * TD);
    drive(1'b0, TD);
    drive(1'b1, 8 * TD);
    chk("R4 present count restarted", std_no, 1);
    drive(1'b1, 3 * TD);
    chk("R4 asserts after full run", std_no, 0);
    drive(1'b0, 22 * TD);

    // R8 short dropout keeps the pulse open, long one closes it
    p_thr = 16'd5;
    a_thr = 16'd3;
    drive(1'b1, 6 * TD);
    drive(1'b0, 3 * TD);
    drive(1'b1, 6 * TD);
    drive(1'b0, 6 * TD);
    chk("R8 three-tick dropout tolerated", valid_o, 1);
    drive(1'b1, 6 * TD);
    chk("R8 valid cleared at pulse start", valid_o, 0);
    drive(1'b0, 5 * TD);
    chk("R8 long dropout closes short pulse", valid_o, 0);
    drive(1'b1, 14 * TD);
    drive(1'b0, 6 * TD);
    chk("R9 in-window pulse valid", valid_o, 1);

    // R10 disable
    en_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 valid cleared by disable", valid_o, 0);
    en_i = 1'b1;
    drive(1'b1, 8 * TD);
    chk("R3 asserted before disable", std_no, 0);
    en_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 std_no forced high", std_no, 1);
    chk("R10 gt_o forced low", gt_o, 0);
    en_i = 1'b1;
    drive(1'b1, 4 * TD);
    chk("R10 counters cleared", std_no, 1);
    drive(1'b1, 2 * TD);
    chk("R2 re-asserts after full guard", std_no, 0);
    drive(1'b0, 8 * TD);
    chk("R5 final release", std_no, 1);

    finish_run();
  end
endmodule